// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Controller

This block runs hardware flow control for one UART channel. On the receive side it compares the receive FIFO occupancy with a pair of thresholds chosen by a 2-bit trigger select. It drives the active-low request-to-send line high (off) when the FIFO becomes too full. It drives the line low (on) again only after the FIFO has drained well below that point. The gap between the two thresholds gives hysteresis, so the line does not chatter when the occupancy sits near one threshold.

On the transmit side it synchronises the active-low clear-to-send input and controls a `tx_allow` permission for the transmitter. When the remote end deasserts CTS, the transmitter finishes the character it is sending and then stops. It starts again once CTS is asserted again. A rising edge of the synchronised CTS level can raise an interrupt flag, which software clears with a one-cycle strobe. Each of the two directions has its own enable. When auto-RTS is off, the RTS pin follows a software-written bit.

Top module: `uart_autoflow`

## Requirements
- R1: While reset is active and in the first cycle after it, `rts_n` is 0, `tx_allow` is 1 and `cts_irq` is 0.
- R2: With `rts_auto_en`=1, an `rx_count` at or above the high threshold makes `rts_n` 1 after the next clock edge. The high threshold is 8, 16, 24 or 28 for `trig_sel` values 0, 1, 2 or 3.
- R3: With `rts_auto_en`=1, an `rx_count` at or below the low threshold makes `rts_n` 0 after the next clock edge. The low threshold is 0, 7, 15 or 23 for `trig_sel` values 0, 1, 2 or 3.
- R4: With `rts_auto_en`=1 and `rx_count` strictly between the two thresholds, `rts_n` keeps its value. RTS stays off for every count up to a full FIFO of 32.
- R5: With `rts_auto_en`=0, `rts_n` takes the value of `rts_sw` one clock edge later.
- R6: `cts_n` passes through a two-flop synchroniser. A change on the pin reaches `tx_allow` and `cts_irq` at the third rising edge after it. With `cts_auto_en`=1 and the synchronised CTS at 1, `tx_allow` falls only at an edge where `tx_char_done` is 1.
- R7: With `cts_auto_en`=1, a synchronised CTS of 0 drives `tx_allow` to 1.
- R8: With `cts_auto_en`=0, `tx_allow` stays 1 whatever `cts_n` and `tx_char_done` do.
- R9: A 0-to-1 transition of the synchronised CTS sets `cts_irq` only when `cts_irq_en` is 1.
- R10: `irq_clr` clears `cts_irq` at the next edge. If a set and a clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rts_auto_en | input | 1 | Enables automatic RTS |
| cts_auto_en | input | 1 | Enables automatic CTS gating of the transmitter |
| cts_irq_en | input | 1 | Enables the CTS-change interrupt flag |
| trig_sel | input | 2 | Selects the threshold pair (0..3) |
| rx_count | input | 6 | Receive FIFO occupancy, 0..32 |
| rts_sw | input | 1 | Software RTS level, used when auto-RTS is off |
| cts_n | input | 1 | Asynchronous clear-to-send pin, 1 = stop |
| tx_char_done | input | 1 | Transmitter has shifted out a stop bit or is idle |
| irq_clr | input | 1 | One-cycle clear strobe for `cts_irq` |
| rts_n | output | 1 | Request-to-send pin, 1 = off |
| tx_allow | output | 1 | Transmitter may start a character |
| cts_irq | output | 1 | CTS-change interrupt flag |

## Verification
On every cycle, the assertions check the threshold responses of RTS (R2, R3, R4), software pass-through (R5), that `tx_allow` falls only at a character boundary (R6), that it is held high when gating is disabled (R8), and the gating and clearing of the interrupt flag (R9, R10). The synchroniser latency, resumption after CTS returns (R7), and the rule that a set beats a clear on the same edge can be shown only by the bench's timed scenarios and its cycle-by-cycle model. The same applies to the complete hysteresis ramps up to a full FIFO for all four trigger selections.

// File: rtl/uart_autoflow.sv
module uart_autoflow #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rts_auto_en,
  input  logic             cts_auto_en,
  input  logic             cts_irq_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rts_sw,
  input  logic             cts_n,
  input  logic             tx_char_done,
  input  logic             irq_clr,
  output logic             rts_n,
  output logic             tx_allow,
  output logic             cts_irq
);

  localparam logic [CNT_W-1:0] HI0 = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] HI1 = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] HI2 = CNT_W'(3 * DEPTH / 4);
  localparam logic [CNT_W-1:0] HI3 = CNT_W'(DEPTH - DEPTH / 8);
  localparam logic [CNT_W-1:0] LO0 = '0;
  localparam logic [CNT_W-1:0] LO1 = HI0 - 1'b1;
  localparam logic [CNT_W-1:0] LO2 = HI1 - 1'b1;
  localparam logic [CNT_W-1:0] LO3 = HI2 - 1'b1;

  logic [CNT_W-1:0] hi_th, lo_th;
  logic             cts_s1, cts_s2, cts_s3;
  logic             rts_nxt, cts_rise;

  always_comb begin
    case (trig_sel)
      2'd0:    begin hi_th = HI0; lo_th = LO0; end
      2'd1:    begin hi_th = HI1; lo_th = LO1; end
      2'd2:    begin hi_th = HI2; lo_th = LO2; end
      default: begin hi_th = HI3; lo_th = LO3; end
    endcase
  end

  always_comb begin
    if (!rts_auto_en)            rts_nxt = rts_sw;
    else if (rx_count >= hi_th)  rts_nxt = 1'b1;
    else if (rx_count <= lo_th)  rts_nxt = 1'b0;
    else                         rts_nxt = rts_n;
  end

  assign cts_rise = cts_s2 & ~cts_s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_s1   <= 1'b0;
      cts_s2   <= 1'b0;
      cts_s3   <= 1'b0;
      rts_n    <= 1'b0;
      tx_allow <= 1'b1;
      cts_irq  <= 1'b0;
    end else begin
      cts_s1 <= cts_n;
      cts_s2 <= cts_s1;
      cts_s3 <= cts_s2;
      rts_n  <= rts_nxt;
      if (!cts_auto_en || !cts_s2) tx_allow <= 1'b1;
      else if (tx_char_done)       tx_allow <= 1'b0;
      if (cts_rise && cts_irq_en)  cts_irq  <= 1'b1;
      else if (irq_clr)            cts_irq  <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_autoflow_chk.sv
module uart_autoflow_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rts_auto_en,
  input logic             cts_auto_en,
  input logic             cts_irq_en,
  input logic [1:0]       trig_sel,
  input logic [CNT_W-1:0] rx_count,
  input logic             rts_sw,
  input logic             cts_n,
  input logic             tx_char_done,
  input logic             irq_clr,
  input logic             rts_n,
  input logic             tx_allow,
  input logic             cts_irq
);

  int unsigned hi, lo;
  always_comb begin
    case (trig_sel)
      2'd0:    begin hi = DEPTH / 4;         lo = 0; end
      2'd1:    begin hi = DEPTH / 2;         lo = DEPTH / 4 - 1; end
      2'd2:    begin hi = 3 * DEPTH / 4;     lo = DEPTH / 2 - 1; end
      default: begin hi = DEPTH - DEPTH / 8; lo = 3 * DEPTH / 4 - 1; end
    endcase
  end

  logic cnt_hi, cnt_lo;
  assign cnt_hi = int'(rx_count) >= hi;
  assign cnt_lo = int'(rx_count) <= lo;

  a_r2_rts_off: assert property (@(posedge clk) disable iff (!rst_n)
    rts_auto_en && cnt_hi |=> rts_n);
  a_r3_rts_on: assert property (@(posedge clk) disable iff (!rst_n)
    rts_auto_en && cnt_lo |=> !rts_n);
  a_r4_rts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rts_auto_en && !cnt_hi && !cnt_lo |=> rts_n == $past(rts_n));
  a_r5_rts_sw: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_auto_en |=> rts_n == $past(rts_sw));
  a_r6_pause_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_allow) |-> $past(tx_char_done) && $past(cts_auto_en));
  a_r8_gating_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_auto_en |=> tx_allow);
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_irq) |-> $past(cts_irq_en));
  a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !cts_irq_en |=> !cts_irq);

endmodule

bind uart_autoflow uart_autoflow_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/uart_autoflow_tb.sv
module uart_autoflow_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rts_auto_en = 0, cts_auto_en = 0, cts_irq_en = 0, rts_sw = 0;
  logic cts_n = 0, tx_char_done = 0, irq_clr = 0;
  logic [1:0] trig_sel = 0;
  logic [5:0] rx_count = 0;
  logic rts_n, tx_allow, cts_irq;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  uart_autoflow u_dut (.clk, .rst_n, .rts_auto_en, .cts_auto_en, .cts_irq_en,
    .trig_sel, .rx_count, .rts_sw, .cts_n, .tx_char_done, .irq_clr,
    .rts_n, .tx_allow, .cts_irq);

  function automatic int hi_of(int s);
    case (s) 0: return 8; 1: return 16; 2: return 24; default: return 28; endcase
  endfunction
  function automatic int lo_of(int s);
    case (s) 0: return 0; 1: return 7; 2: return 15; default: return 23; endcase
  endfunction

  // behavioural reference model
  int pin_q[$] = '{0, 0, 0};
  int m_rts = 0, m_allow = 1, m_irq = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q = '{0, 0, 0}; m_rts = 0; m_allow = 1; m_irq = 0;
    end else begin
      int s2, s3, c;
      s3 = pin_q[0]; s2 = pin_q[1]; c = int'(rx_count);
      if (!rts_auto_en) m_rts = int'(rts_sw);
      else if (c >= hi_of(int'(trig_sel))) m_rts = 1;
      else if (c <= lo_of(int'(trig_sel))) m_rts = 0;
      if (!cts_auto_en || s2 == 0) m_allow = 1;
      else if (tx_char_done) m_allow = 0;
      if (s2 == 1 && s3 == 0 && cts_irq_en) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      pin_q.push_back(int'(cts_n));
      void'(pin_q.pop_front());
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    check("R2 model rts_n", int'(rts_n), m_rts);
    check("R6 model tx_allow", int'(tx_allow), m_allow);
    check("R9 model cts_irq", int'(cts_irq), m_irq);
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(2);
    check("R1 rts_n", int'(rts_n), 0);
    check("R1 tx_allow", int'(tx_allow), 1);
    check("R1 cts_irq", int'(cts_irq), 0);
    rst_n = 1; step(1);
    check("R1 rts_n after", int'(rts_n), 0);

    rts_auto_en = 1;
    for (int s = 0; s < 4; s++) begin
      int exp;
      trig_sel = 2'(s); rx_count = 0; step(1); exp = 0;
      for (int c = 0; c <= 32; c++) begin
        rx_count = 6'(c); step(1);
        if (c >= hi_of(s)) begin exp = 1; check("R2 ramp up", int'(rts_n), 1); end
        else if (c <= lo_of(s)) begin exp = 0; check("R3 ramp up", int'(rts_n), 0); end
        else check("R4 ramp up hold", int'(rts_n), exp);
      end
      for (int c = 32; c >= 0; c--) begin
        rx_count = 6'(c); step(1);
        if (c >= hi_of(s)) check("R2 full stays off", int'(rts_n), 1);
        else if (c <= lo_of(s)) check("R3 drained", int'(rts_n), 0);
        else check("R4 drain hold", int'(rts_n), 1);
      end
    end

    rts_auto_en = 0; rx_count = 30;
    rts_sw = 1; step(1); check("R5 sw high", int'(rts_n), 1);
    rts_sw = 0; step(1); check("R5 sw low", int'(rts_n), 0);
    rts_sw = 1; step(1); check("R5 sw high again", int'(rts_n), 1);
    rts_sw = 0; rx_count = 0; step(1);

    cts_auto_en = 1; cts_irq_en = 1; tx_char_done = 0;
    cts_n = 1; step(2);
    check("R6 sync latency irq", int'(cts_irq), 0);
    step(1);
    check("R9 irq set", int'(cts_irq), 1);
    step(3);
    check("R6 waits for char end", int'(tx_allow), 1);
    tx_char_done = 1; step(1);
    check("R6 paused", int'(tx_allow), 0);
    tx_char_done = 0;
    irq_clr = 1; step(1); irq_clr = 0;
    check("R10 cleared", int'(cts_irq), 0);
    cts_n = 0; step(2);
    check("R7 still paused in sync", int'(tx_allow), 0);
    step(1);
    check("R7 resumed", int'(tx_allow), 1);

    cts_irq_en = 0; cts_n = 1; step(5);
    check("R9 masked", int'(cts_irq), 0);
    cts_n = 0; step(4);

    cts_irq_en = 1; cts_n = 1; step(2);
    irq_clr = 1; step(1); irq_clr = 0;
    check("R10 set wins", int'(cts_irq), 1);
    irq_clr = 1; step(1); irq_clr = 0;
    check("R10 clear", int'(cts_irq), 0);

    cts_auto_en = 0; tx_char_done = 1; step(5);
    check("R8 gating off", int'(tx_allow), 1);
    tx_char_done = 0; cts_n = 0; step(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule